// File: doc/BRIEF.md
# Counter-Compare Watchdog With Offset Reload

This block is a watchdog built on a shared 16-bit counter and one compare channel. The counter advances on a clock-enable tick. While the watchdog is enabled, the channel's high byte is a deadline. When the counter's high byte steps onto that deadline, the block raises a one-cycle reset request. The channel's low byte holds an offset. Software keeps the system alive by writing any value to the deadline register. Each such write re-arms the deadline to the live counter high byte plus the offset, so the timeout is about offset × 256 ticks.

While it is enabled, the watchdog takes ownership of the counter and the channel. The counter is forced to run. Writes to the counter bytes, the clock-source field, the idle field and the channel mode register have no effect. The channel reads back a fixed software-timer mode. A sticky lock bit stops software from turning the watchdog off until the next reset.

Registers are reached through a simple write strobe with an address and data. Reads are combinational from the address.

Top module: `deadline_wdog`

## Requirements
- R1: After reset: MODE (addr 1) reads 8'h01 (enable bit 0 = 1, lock bit 1 = 0). CTRL (addr 0), counter low (addr 2), counter high (addr 3), offset (addr 5) and deadline (addr 6) read 0. `rst_req_o` is 0. Address 7 always reads 0.
- R2: When a tick arrives while the counter runs, the 16-bit counter {addr 3, addr 2} advances by 1 and wraps from 16'hFFFF to 0. The counter runs when either the enable bit or the CTRL run bit (bit 0) is 1. Without a tick, or when the counter is stopped, it holds its value.
- R3: While enabled, a write of any data to addr 6 loads the deadline with (counter high byte + offset) mod 256, using the counter value from before that edge. If this write falls in the same cycle as a matching overflow tick, the re-arm takes effect and no reset is produced.
- R4: While enabled, a tick that carries the counter low byte from 8'hFF to 0 makes the new high byte available for comparison. If that new high byte equals the deadline, `rst_req_o` is 1 for exactly the next cycle. After a re-arm with counter low byte 0 and no further writes, this happens after offset × 256 ticks.
- R5: The CTRL run bit (bit 0) always stores the written value and reads back what software wrote. It reads 0 while enabled unless software set it, even though the counter is forced to run.
- R6: While enabled, writes to addr 2 and addr 3 are ignored. So are writes to CTRL bit 1 (idle) and CTRL bits 4:2 (clock source); those fields keep their values.
- R7: While enabled, the channel mode register (addr 4) reads 8'h48 and ignores writes. When disabled, it reads the last value written while disabled.
- R8: Writing MODE with bit 1 = 1 sets the lock bit. The lock bit stays set until reset. While the lock bit is set, a MODE write with bit 0 = 0 leaves the enable bit at 1. Writing bit 0 = 1 always sets the enable bit.
- R9: When disabled: `rst_req_o` stays 0; counter byte writes take effect; a write to addr 6 stores the write data; the counter keeps its value unless the run bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter clock enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The critical collision is a deadline write landing in the same cycle as the overflow tick that would otherwise match. The bench provokes it by watching its own model. It waits until the counter low byte is 8'hFF and the next high byte equals the deadline, then drives the re-arm write and the tick together. It then judges two things: no reset pulse follows, and the deadline reads back as the pre-edge high byte plus the offset. A second overlap is a counter byte write together with a tick while disabled and running; there the write wins and the tick is dropped for that cycle.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_MODE = 3'd1,
    A_CLO  = 3'd2,
    A_CHI  = 3'd3,
    A_CHM  = 3'd4,
    A_OFF  = 3'd5,
    A_DL   = 3'd6
  } reg_addr_e;

  localparam logic [7:0] SWT_MODE = 8'h48;
endpackage

// File: rtl/wdc_ctrl.sv
module wdc_ctrl #(
  parameter int unsigned BW    = 8,
  parameter int unsigned SRC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             mode_we_i,
  input  logic [BW-1:0]    wdata_i,
  output logic             sw_run_o,
  output logic             idle_o,
  output logic [SRC_W-1:0] src_o,
  output logic             wd_en_o,
  output logic             wd_lock_o
);
  logic             sw_run_q, idle_q, en_q, lock_q;
  logic [SRC_W-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_run_q <= 1'b0;
      idle_q   <= 1'b0;
      src_q    <= '0;
    end else if (ctrl_we_i) begin
      sw_run_q <= wdata_i[0];
      if (!en_q) begin
        idle_q <= wdata_i[1];
        src_q  <= wdata_i[SRC_W+1:2];
      end
    end
  end

  // enable comes up set; lock is sticky until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b1;
      lock_q <= 1'b0;
    end else if (mode_we_i) begin
      if (wdata_i[1]) lock_q <= 1'b1;
      if (wdata_i[0])   en_q <= 1'b1;
      else if (!lock_q) en_q <= 1'b0;
    end
  end

  assign sw_run_o  = sw_run_q;
  assign idle_o    = idle_q;
  assign src_o     = src_q;
  assign wd_en_o   = en_q;
  assign wd_lock_o = lock_q;
endmodule

// File: rtl/wdc_counter.sv
module wdc_counter #(
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          lo_we_i,
  input  logic          hi_we_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] cnt_lo_o,
  output logic [BW-1:0] cnt_hi_o,
  output logic [BW-1:0] hi_next_o,
  output logic          ovf_o
);
  localparam int unsigned CW = 2 * BW;

  logic [CW-1:0] cnt_q;
  logic          adv;

  // a byte write owns the cycle; the tick is dropped
  assign adv       = tick_i & run_i & ~(lo_we_i | hi_we_i);
  assign ovf_o     = adv & (&cnt_q[BW-1:0]);
  assign hi_next_o = cnt_q[CW-1:BW] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (lo_we_i || hi_we_i) begin
      if (lo_we_i) cnt_q[BW-1:0]  <= wdata_i;
      if (hi_we_i) cnt_q[CW-1:BW] <= wdata_i;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_lo_o = cnt_q[BW-1:0];
  assign cnt_hi_o = cnt_q[CW-1:BW];
endmodule

// File: rtl/wdc_chan.sv
module wdc_chan #(
  parameter int unsigned  BW       = 8,
  parameter logic [BW-1:0] SWT_VAL = 8'h48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wd_en_i,
  input  logic          chm_we_i,
  input  logic          off_we_i,
  input  logic          dl_we_i,
  input  logic [BW-1:0] wdata_i,
  input  logic [BW-1:0] cnt_hi_i,
  input  logic [BW-1:0] hi_next_i,
  input  logic          ovf_i,
  output logic [BW-1:0] offset_o,
  output logic [BW-1:0] deadline_o,
  output logic [BW-1:0] chm_o,
  output logic          rst_req_o
);
  logic [BW-1:0] off_q, dl_q, chm_q;
  logic          rst_q, hit;

  // re-arm in the same cycle beats the match
  assign hit = wd_en_i & ovf_i & (hi_next_i == dl_q) & ~dl_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      dl_q  <= '0;
      chm_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= hit;
      if (off_we_i) off_q <= wdata_i;
      if (chm_we_i && !wd_en_i) chm_q <= wdata_i;
      if (dl_we_i) dl_q <= wd_en_i ? (cnt_hi_i + off_q) : wdata_i;
    end
  end

  assign offset_o   = off_q;
  assign deadline_o = dl_q;
  assign chm_o      = wd_en_i ? SWT_VAL : chm_q;
  assign rst_req_o  = rst_q;
endmodule

// File: rtl/deadline_wdog.sv
module deadline_wdog
  import wdc_pkg::*;
#(
  parameter int unsigned BW    = 8,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned SRC_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o,
  output logic          rst_req_o
);
  localparam int unsigned CPAD = BW - SRC_W - 2;

  logic             sw_run, idle, wd_en, wd_lock, ovf;
  logic [SRC_W-1:0] src;
  logic [BW-1:0]    cnt_lo, cnt_hi, hi_next, offset, deadline, chm;
  logic             we_ctrl, we_mode, we_lo, we_hi, we_chm, we_off, we_dl;

  assign we_ctrl = we_i & (addr_i == A_CTRL);
  assign we_mode = we_i & (addr_i == A_MODE);
  assign we_lo   = we_i & (addr_i == A_CLO) & ~wd_en;
  assign we_hi   = we_i & (addr_i == A_CHI) & ~wd_en;
  assign we_chm  = we_i & (addr_i == A_CHM);
  assign we_off  = we_i & (addr_i == A_OFF);
  assign we_dl   = we_i & (addr_i == A_DL);

  wdc_ctrl #(.BW(BW), .SRC_W(SRC_W)) u_ctrl (
    .clk_i, .rst_ni,
    .ctrl_we_i(we_ctrl), .mode_we_i(we_mode), .wdata_i,
    .sw_run_o(sw_run), .idle_o(idle), .src_o(src),
    .wd_en_o(wd_en), .wd_lock_o(wd_lock)
  );

  wdc_counter #(.BW(BW)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .run_i(wd_en | sw_run),
    .lo_we_i(we_lo), .hi_we_i(we_hi), .wdata_i,
    .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi), .hi_next_o(hi_next), .ovf_o(ovf)
  );

  wdc_chan #(.BW(BW), .SWT_VAL(BW'(SWT_MODE))) u_chan (
    .clk_i, .rst_ni, .wd_en_i(wd_en),
    .chm_we_i(we_chm), .off_we_i(we_off), .dl_we_i(we_dl), .wdata_i,
    .cnt_hi_i(cnt_hi), .hi_next_i(hi_next), .ovf_i(ovf),
    .offset_o(offset), .deadline_o(deadline), .chm_o(chm), .rst_req_o
  );

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {{CPAD{1'b0}}, src, idle, sw_run};
      A_MODE:  rdata_o = {{(BW-2){1'b0}}, wd_lock, wd_en};
      A_CLO:   rdata_o = cnt_lo;
      A_CHI:   rdata_o = cnt_hi;
      A_CHM:   rdata_o = chm;
      A_OFF:   rdata_o = offset;
      A_DL:    rdata_o = deadline;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdc_checker.sv
module wdc_checker
  import wdc_pkg::*;
#(
  parameter int unsigned BW = 8,
  parameter int unsigned AW = ADDR_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic          rst_req_o,
  input logic          wd_en,
  input logic          wd_lock,
  input logic [BW-1:0] cnt_lo,
  input logic [BW-1:0] cnt_hi,
  input logic [BW-1:0] offset,
  input logic [BW-1:0] deadline
);
  logic [BW-1:0] rearm_val;
  assign rearm_val = cnt_hi + offset;

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  a_r9_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en |=> !rst_req_o);

  a_r8_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_lock |=> wd_lock);

  a_r8_en_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_lock && wd_en) |=> wd_en);

  a_r6_cnt_unwritable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_en && !tick_i) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  a_r3_rearm_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_en && we_i && addr_i == A_DL) |=> deadline == $past(rearm_val));
endmodule

bind deadline_wdog wdc_checker #(.BW(BW), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .tick_i, .we_i, .addr_i, .rst_req_o,
  .wd_en(wd_en), .wd_lock(wd_lock), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .offset(offset), .deadline(deadline)
);

// File: tb/deadline_wdog_bench.sv
module deadline_wdog_bench;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       tick_i = 1'b0, we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rst_req_o;

  deadline_wdog u_deadline_wdog (.*);

  always #10 clk_i = ~clk_i;

  int total = 0, bad = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference model
  int m_cnt, m_off, m_dl, m_chm, m_src, m_idle, m_run, m_en, m_lock, m_rst;

  task automatic m_reset();
    m_cnt = 0; m_off = 0; m_dl = 0; m_chm = 0; m_src = 0; m_idle = 0;
    m_run = 0; m_en = 1; m_lock = 0; m_rst = 0;
  endtask

  initial m_reset();

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_reset();
    else begin
      int hi, lo, nhi, cw, ovf, n_rst, n_cnt, n_dl;
      hi = m_cnt / 256; lo = m_cnt % 256;
      cw = (we_i && !m_en && (addr_i == 2 || addr_i == 3)) ? 1 : 0;
      ovf = (tick_i && (m_en || m_run) && !cw && lo == 255) ? 1 : 0;
      nhi = (hi + 1) % 256;
      n_rst = (m_en && ovf && nhi == m_dl && !(we_i && addr_i == 6)) ? 1 : 0;
      n_cnt = m_cnt;
      if (cw) begin
        if (addr_i == 2) n_cnt = hi * 256 + int'(wdata_i);
        else             n_cnt = int'(wdata_i) * 256 + lo;
      end else if (tick_i && (m_en || m_run)) n_cnt = (m_cnt + 1) % 65536;
      n_dl = m_dl;
      if (we_i && addr_i == 6) n_dl = m_en ? (hi + m_off) % 256 : int'(wdata_i);
      if (we_i) begin
        case (addr_i)
          0: begin
            m_run = int'(wdata_i[0]);
            if (!m_en) begin m_idle = int'(wdata_i[1]); m_src = int'(wdata_i[4:2]); end
          end
          1: begin
            if (wdata_i[1]) m_lock = 1;
            if (wdata_i[0]) m_en = 1;
            else if (!m_lock) m_en = 0;
          end
          4: if (!m_en) m_chm = int'(wdata_i);
          5: m_off = int'(wdata_i);
          default: ;
        endcase
      end
      m_cnt = n_cnt; m_dl = n_dl; m_rst = n_rst;
    end
  end

  function automatic int m_read(int a);
    case (a)
      0: return m_src * 4 + m_idle * 2 + m_run;
      1: return m_lock * 2 + m_en;
      2: return m_cnt % 256;
      3: return m_cnt / 256;
      4: return m_en ? 8'h48 : m_chm;
      5: return m_off;
      6: return m_dl;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // wait for a negedge and compare against the model
  task automatic wait_neg();
    @(negedge clk_i);
    cycles++;
    if (rst_ni) begin
      check(rst_req_o == m_rst[0], "R4", int'(rst_req_o), m_rst);
      check(int'(rdata_o) == m_read(int'(addr_i)), tag, int'(rdata_o), m_read(int'(addr_i)));
    end
  endtask

  task automatic drive(bit we, int a, int d, bit t);
    we_i = we; addr_i = 3'(a); wdata_i = 8'(d); tick_i = t;
  endtask

  task automatic step(bit we, int a, int d, bit t);
    wait_neg(); drive(we, a, d, t);
  endtask

  task automatic wr(int a, int d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic rd(int a, int exp, string req);
    step(1'b0, a, 0, 1'b0);
    #1 check(int'(rdata_o) == exp, req, int'(rdata_o), exp);
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0; drive(0, 0, 0, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int n, exp_dl, seen;
    do_reset();
    tag = "R1";
    rd(1, 8'h01, "R1"); rd(0, 0, "R1"); rd(2, 0, "R1"); rd(3, 0, "R1");
    rd(5, 0, "R1"); rd(6, 0, "R1"); rd(7, 0, "R1");
    check(rst_req_o == 1'b0, "R1", int'(rst_req_o), 0);

    tag = "R6";
    wr(3, 8'h77); wr(2, 8'h12); rd(3, 0, "R6"); rd(2, 0, "R6");
    wr(0, 8'h1E); rd(0, 0, "R6");
    tag = "R5";
    wr(0, 8'h01); rd(0, 8'h01, "R5");
    wr(0, 8'h00); rd(0, 8'h00, "R5");
    tag = "R7";
    wr(4, 8'h33); rd(4, 8'h48, "R7");

    tag = "R2";
    for (int i = 0; i < 300; i++) step(0, 3, 0, 1'b1);
    rd(3, 1, "R2"); rd(2, 300 % 256 - 0, "R2");
    rd(3, 1, "R2");

    // periodic re-arm holds off the reset
    tag = "R3";
    wr(5, 3);
    seen = 0;
    for (int i = 0; i < 2400; i++) begin
      wait_neg();
      if (rst_req_o) seen++;
      if (i % 300 == 0) drive(1, 6, 8'hC3, 1'b1); else drive(0, 6, 0, 1'b1);
    end
    wait_neg(); if (rst_req_o) seen++;
    check(seen == 0, "R3", seen, 0);

    // collision: re-arm on the matching overflow tick
    n = 0;
    forever begin
      wait_neg();
      n++;
      if (m_cnt % 256 == 255 && ((m_cnt / 256 + 1) % 256) == m_dl) begin
        exp_dl = (m_cnt / 256 + m_off) % 256;
        drive(1, 6, 8'hA5, 1'b1);
        break;
      end
      drive(0, 6, 0, 1'b1);
      if (n > 2000) break;
    end
    step(0, 6, 0, 1'b0);
    check(rst_req_o == 1'b0, "R3", int'(rst_req_o), 0);
    #1 check(int'(rdata_o) == exp_dl, "R3", int'(rdata_o), exp_dl);

    // exact timeout: disable, zero counter, enable, re-arm at low byte 0
    tag = "R9";
    wr(1, 0); rd(1, 0, "R9");
    wr(2, 0); wr(3, 0); rd(3, 0, "R9"); rd(2, 0, "R9");
    for (int i = 0; i < 20; i++) step(0, 2, 0, 1'b1);
    rd(2, 0, "R9");
    tag = "R4";
    wr(1, 1); wr(5, 3); wr(6, 8'hEE); rd(6, 3, "R3");
    n = 0;
    forever begin
      wait_neg();
      if (rst_req_o || n > 1000) break;
      drive(0, 3, 0, 1'b1); n++;
    end
    check(n == 3 * 256, "R4", n, 768);
    step(0, 3, 0, 1'b0);
    check(rst_req_o == 1'b0, "R4", int'(rst_req_o), 0);

    // lock
    tag = "R8";
    wr(1, 8'h03); rd(1, 8'h03, "R8");
    wr(1, 8'h00); rd(1, 8'h03, "R8");
    wr(4, 8'h11); rd(4, 8'h48, "R7");
    do_reset();
    tag = "R1";
    rd(1, 8'h01, "R8");

    // disabled: writes land, no reset even on a match
    tag = "R9";
    wr(1, 0);
    wr(4, 8'h11); rd(4, 8'h11, "R7");
    wr(0, 8'h1D); rd(0, 8'h1D, "R6");
    wr(6, 8'h5A); rd(6, 8'h5A, "R9");
    wr(3, 8'h59); wr(2, 8'hF0); rd(2, 8'hF0, "R9");
    // counter write and tick together: write wins
    wait_neg(); drive(1, 2, 8'hF8, 1'b1);
    rd(2, 8'hF8, "R2");
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      wait_neg(); if (rst_req_o) seen++; drive(0, 3, 0, 1'b1);
    end
    check(seen == 0, "R9", seen, 0);
    rd(3, 8'h5A, "R2");

    wait_neg();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule